// File: doc/BRIEF.md
# Debug Data-Transfer Register Interface

This block sits between an external debugger on an APB bus and a processor core. The debugger passes data to the core through a receive data register and takes data back through a transmit data register. It passes instructions through an instruction register. The block keeps three live flags: receive-full, transmit-full and instruction-complete. It also keeps copies of those flags that are captured each time the debugger reads the status register. A 2-bit mode field selects how the debugger's accesses are gated.

In non-blocking mode, an access that the captured copies forbid is dropped. The debugger can later read the status register and see whether the access took effect. In stall mode, the APB transfer is held with PREADY low until the live flag allows it. Fast mode stalls in the same way. In addition, every successful data transfer in fast mode reissues the held instruction to the core. The core side uses valid/ready handshakes for the two data registers, a one-cycle issue pulse for instructions, and a done pulse when an instruction finishes.

Top module: `dbg_xfer_regs`

## Requirements
- R1: After reset, the block is in the following state:
  - the mode is non-blocking;
  - receive-full and transmit-full are 0, and instruction-complete is 1;
  - the captured copies hold the same values as the live flags;
  - PREADY is high, `core_rx_valid` is 0, `core_tx_ready` is 1 and `core_instr_go` is 0.
- R2: A read at offset 0x0 returns the status word and copies the three live flags into their captured copies. The status word has the following layout:
  - bit 0 is receive-full;
  - bit 1 is transmit-full;
  - bit 2 is instruction-complete;
  - bits 5:4 are the mode;
  - all other bits are 0.
- R3: A write at offset 0x0 changes only the mode bits 5:4. The mode encodings are: 00 non-blocking, 01 stall, 10 fast, and 11 behaves as stall.
- R4: In non-blocking mode, a write at offset 0x4 (receive data) is dropped while the captured receive-full copy is 1. A write that succeeds stores the data and sets both the live and the captured receive-full flags.
- R5: In non-blocking mode, a read at offset 0x8 (transmit data) leaves the flags unchanged while the captured transmit-full copy is 0. A read that succeeds returns the data and clears both the live and the captured transmit-full flags.
- R6: In non-blocking mode, a write at offset 0xC (instruction) is dropped while the captured complete copy is 0. A write that succeeds does three things:
  - it stores the instruction;
  - it pulses `core_instr_go` for one cycle, with the instruction on `core_instr`;
  - it clears both the live and the captured complete flags.
- R7: In non-blocking mode, PREADY is never low during an access.
- R8: In stall mode, PREADY is held low while one of these conditions holds:
  - a receive-data write finds receive-full set;
  - a transmit-data read finds transmit-full clear;
  - an instruction write finds instruction-complete clear.

  The access completes in the cycle after its condition becomes true. An instruction write that completes in stall mode issues the instruction.
- R9: In fast mode, the block stalls as it does in stall mode. Every completed receive-data write or transmit-data read issues the held instruction. An instruction write only loads the register and issues nothing.
- R10: On the core side:
  - `core_rx_valid` reflects receive-full, and a handshake on it clears the flag;
  - `core_tx_ready` is the inverse of transmit-full, and a push sets the flag and stores the data;
  - a `core_instr_done` pulse sets instruction-complete;
  - every issue clears instruction-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 4 | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready; low while an access is stalled |
| core_rx_data | output | DATA_W | Receive data toward the core |
| core_rx_valid | output | 1 | Receive data present |
| core_rx_ready | input | 1 | Core takes the receive data |
| core_tx_data | input | DATA_W | Transmit data from the core |
| core_tx_valid | input | 1 | Core offers transmit data |
| core_tx_ready | output | 1 | Transmit register empty |
| core_instr | output | DATA_W | Held instruction |
| core_instr_go | output | 1 | One-cycle instruction issue pulse |
| core_instr_done | input | 1 | Pulse from the core when an instruction finishes |

## Verification
The assertions take the following for granted about the block's inputs:
- An APB master keeps `psel`, `paddr`, `pwrite` and `pwdata` steady while PREADY is low.
- The core pulses `core_instr_done` only after an issue.
- The core asserts `core_rx_ready` only while `core_rx_valid` is high, and `core_tx_valid` only while `core_tx_ready` is high.

The stimulus stays within these rules. APB transfers are driven by one task, which changes the bus only after PREADY has been seen high. The core-side handshakes are raised only where the flags already permit them, and a done pulse is issued only after an issue pulse has been observed.

// File: rtl/dbg_xfer_regs.sv
module dbg_xfer_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [3:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic [DATA_W-1:0] core_rx_data,
  output logic              core_rx_valid,
  input  logic              core_rx_ready,
  input  logic [DATA_W-1:0] core_tx_data,
  input  logic              core_tx_valid,
  output logic              core_tx_ready,
  output logic [DATA_W-1:0] core_instr,
  output logic              core_instr_go,
  input  logic              core_instr_done
);
  localparam logic [1:0] SEL_STAT = 2'd0, SEL_RXD = 2'd1, SEL_TXD = 2'd2, SEL_INS = 2'd3;
  localparam logic [1:0] MODE_NB = 2'd0, MODE_FAST = 2'd2;

  logic [1:0]        mode;
  logic              rx_full, tx_full, done;
  logic              rx_cap, tx_cap, done_cap;
  logic [DATA_W-1:0] rx_q, tx_q, ins_q;
  logic              go_q;

  wire [1:0] sel   = paddr[3:2];
  wire       stalls = (mode != MODE_NB);
  wire       fast   = (mode == MODE_FAST);
  wire       access = psel && penable;

  logic cond;
  always_comb begin
    cond = 1'b1;
    if (pwrite && sel == SEL_RXD)  cond = !rx_full;
    if (pwrite && sel == SEL_INS)  cond = done;
    if (!pwrite && sel == SEL_TXD) cond = tx_full;
  end

  assign pready = !stalls || cond;
  wire acc = access && pready;

  wire rx_wr_ok = acc && pwrite  && sel == SEL_RXD && (stalls || !rx_cap);
  wire tx_rd_ok = acc && !pwrite && sel == SEL_TXD && (stalls || tx_cap);
  wire in_wr_ok = acc && pwrite  && sel == SEL_INS && (stalls || done_cap);
  wire st_rd    = acc && !pwrite && sel == SEL_STAT;
  wire st_wr    = acc && pwrite  && sel == SEL_STAT;
  wire issue    = fast ? (rx_wr_ok || tx_rd_ok) : in_wr_ok;

  wire [DATA_W-1:0] status = DATA_W'({mode, 1'b0, done, tx_full, rx_full});
  always_comb begin
    case (sel)
      SEL_STAT: prdata = status;
      SEL_TXD:  prdata = tx_q;
      default:  prdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_NB;
      rx_full <= 1'b0; tx_full <= 1'b0; done <= 1'b1;
      rx_cap <= 1'b0; tx_cap <= 1'b0; done_cap <= 1'b1;
      rx_q <= '0; tx_q <= '0; ins_q <= '0;
      go_q <= 1'b0;
    end else begin
      go_q <= issue;
      if (st_wr) mode <= pwdata[5:4];

      if (rx_wr_ok) begin
        rx_q <= pwdata; rx_full <= 1'b1; rx_cap <= 1'b1;
      end else begin
        if (core_rx_ready && rx_full) rx_full <= 1'b0;
        if (st_rd) rx_cap <= rx_full;
      end

      if (tx_rd_ok) begin
        tx_full <= 1'b0; tx_cap <= 1'b0;
      end else begin
        if (core_tx_valid && !tx_full) begin
          tx_full <= 1'b1; tx_q <= core_tx_data;
        end
        if (st_rd) tx_cap <= tx_full;
      end

      if (in_wr_ok) ins_q <= pwdata;
      if (issue) done <= 1'b0;
      else if (core_instr_done) done <= 1'b1;
      if (in_wr_ok && !fast) done_cap <= 1'b0;
      else if (st_rd) done_cap <= done;
    end
  end

  assign core_rx_data  = rx_q;
  assign core_rx_valid = rx_full;
  assign core_tx_ready = !tx_full;
  assign core_instr    = ins_q;
  assign core_instr_go = go_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    access && !pready |=> psel && $stable(paddr) && $stable(pwrite) && $stable(pwdata)); // R8
  AST_NB_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    access && mode == MODE_NB |-> pready); // R7
  AST_STALL_RX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    access && pwrite && sel == SEL_RXD && stalls && rx_full |-> !pready); // R8
  AST_RX_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_ok |=> core_rx_valid); // R4
  AST_TX_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd_ok |=> core_tx_ready); // R5
  AST_GO_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    core_instr_go |-> !done); // R10
  AST_FAST_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    fast && access && pwrite && sel == SEL_RXD && pready |=> core_instr_go); // R9
endmodule

// File: tb/sim_dbg_xfer_regs.sv
module sim_dbg_xfer_regs;
  localparam int P = 10;
  localparam logic [3:0] A_ST = 4'h0, A_RX = 4'h4, A_TX = 4'h8, A_IN = 4'hC;
  // op: 0 apb write, 1 apb read+check, 2 apb read no check, 3 core push tx, 4 core take rx+check
  localparam logic [71:0] TBL [14] = '{
    {4'd1, A_ST, 32'h0,  32'h4},
    {4'd0, A_RX, 32'h11, 32'h0},
    {4'd1, A_ST, 32'h0,  32'h5},
    {4'd0, A_RX, 32'h22, 32'h0},
    {4'd4, A_RX, 32'h0,  32'h11},
    {4'd0, A_RX, 32'h33, 32'h0},
    {4'd1, A_ST, 32'h0,  32'h4},
    {4'd0, A_RX, 32'h44, 32'h0},
    {4'd4, A_RX, 32'h0,  32'h44},
    {4'd2, A_TX, 32'h0,  32'h0},
    {4'd3, A_TX, 32'hAB, 32'h0},
    {4'd1, A_ST, 32'h0,  32'h6},
    {4'd1, A_TX, 32'h0,  32'hAB},
    {4'd1, A_ST, 32'h0,  32'h4}
  };

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata, core_rx_data, core_tx_data = 0, core_instr;
  logic pready, core_rx_valid, core_rx_ready = 0, core_tx_valid = 0, core_tx_ready;
  logic core_instr_go, core_instr_done = 0;
  int checks = 0, fails = 0, issues = 0;
  logic [31:0] last_ins = 0;

  always #(P/2) clk = ~clk;

  dbg_xfer_regs #(.DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .core_rx_data(core_rx_data), .core_rx_valid(core_rx_valid), .core_rx_ready(core_rx_ready),
    .core_tx_data(core_tx_data), .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready),
    .core_instr(core_instr), .core_instr_go(core_instr_go), .core_instr_done(core_instr_done));

  always @(negedge clk) if (core_instr_go) begin issues++; last_ins = core_instr; end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int st);
    @(negedge clk); psel = 1; pwrite = w; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; st = 0;
    #1;
    while (!pready) begin @(negedge clk); #1; st++; end
    rd = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); core_tx_data = d; core_tx_valid = 1;
    @(negedge clk); core_tx_valid = 0;
  endtask

  task automatic take(input logic [31:0] exp, input string req);
    @(negedge clk); #1;
    chk(core_rx_valid === 1'b1, req, {31'b0, core_rx_valid}, 32'h1);
    chk(core_rx_data === exp, req, core_rx_data, exp);
    core_rx_ready = 1;
    @(negedge clk); core_rx_ready = 0;
  endtask

  task automatic pulse_done;
    @(negedge clk); core_instr_done = 1;
    @(negedge clk); core_instr_done = 0;
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  initial begin
    #(P*150000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st, n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset state
    chk(pready === 1'b1, "R1", {31'b0, pready}, 32'h1);
    chk(core_rx_valid === 1'b0 && core_tx_ready === 1'b1 && issues == 0, "R1",
        {30'b0, core_rx_valid, core_tx_ready}, 32'h1);

    for (int i = 0; i < 14; i++) begin
      logic [3:0] op; logic [3:0] a; logic [31:0] d, e;
      {op, a, d, e} = TBL[i];
      case (op)
        4'd0: apb(1'b1, a, d, rd, st);
        4'd1: begin
          apb(1'b0, a, d, rd, st);
          chk(rd === e, (a == A_TX) ? "R5" : "R2", rd, e);
        end
        4'd2: apb(1'b0, a, d, rd, st);
        4'd3: push(d);
        default: take(e, "R4");
      endcase
    end

    // R6 non-blocking instruction writes
    n0 = issues;
    apb(1'b1, A_IN, 32'hE1, rd, st); settle();
    chk(issues == n0 + 1 && last_ins == 32'hE1, "R6", last_ins, 32'hE1);
    apb(1'b1, A_IN, 32'hE2, rd, st); settle();
    chk(issues == n0 + 1, "R6", issues, n0 + 1);
    apb(1'b0, A_ST, 0, rd, st);
    chk(rd === 32'h0, "R6", rd, 32'h0);
    pulse_done();
    apb(1'b1, A_IN, 32'hE3, rd, st); settle();
    chk(issues == n0 + 1, "R6", issues, n0 + 1);
    apb(1'b0, A_ST, 0, rd, st);
    chk(rd === 32'h4, "R10", rd, 32'h4);
    apb(1'b1, A_IN, 32'hE4, rd, st); settle();
    chk(issues == n0 + 2 && last_ins == 32'hE4, "R6", last_ins, 32'hE4);
    pulse_done();

    // R3 mode field
    apb(1'b1, A_ST, 32'hFFFFFFFF, rd, st);
    apb(1'b0, A_ST, 0, rd, st);
    chk(rd === 32'h34, "R3", rd, 32'h34);
    apb(1'b1, A_ST, 32'h10, rd, st);
    apb(1'b0, A_ST, 0, rd, st);
    chk(rd === 32'h14, "R3", rd, 32'h14);

    // R8 stall mode
    apb(1'b1, A_RX, 32'h50, rd, st);
    chk(st == 0, "R8", st, 0);
    fork
      apb(1'b1, A_RX, 32'h55, rd, st);
      begin repeat (4) @(negedge clk); take(32'h50, "R8"); end
    join
    chk(st >= 3, "R8", st, 3);
    take(32'h55, "R8");
    fork
      apb(1'b0, A_TX, 0, rd, st);
      begin repeat (4) @(negedge clk); push(32'h77); end
    join
    chk(rd === 32'h77 && st >= 3, "R8", rd, 32'h77);
    n0 = issues;
    apb(1'b1, A_IN, 32'hA1, rd, st); settle();
    chk(issues == n0 + 1 && last_ins == 32'hA1, "R8", last_ins, 32'hA1);
    fork
      apb(1'b1, A_IN, 32'hA2, rd, st);
      begin repeat (4) @(negedge clk); pulse_done(); end
    join
    settle();
    chk(issues == n0 + 2 && last_ins == 32'hA2 && st >= 3, "R8", last_ins, 32'hA2);
    pulse_done();

    // R9 fast mode
    apb(1'b1, A_ST, 32'h20, rd, st);
    n0 = issues;
    apb(1'b1, A_IN, 32'hF0, rd, st); settle();
    chk(issues == n0, "R9", issues, n0);
    apb(1'b1, A_RX, 32'h66, rd, st); settle();
    chk(issues == n0 + 1 && last_ins == 32'hF0, "R9", last_ins, 32'hF0);
    chk(core_rx_valid === 1'b1, "R10", {31'b0, core_rx_valid}, 32'h1);
    take(32'h66, "R10");
    pulse_done();
    push(32'h99); settle();
    chk(core_tx_ready === 1'b0, "R10", {31'b0, core_tx_ready}, 32'h0);
    apb(1'b0, A_TX, 0, rd, st); settle();
    chk(rd === 32'h99 && issues == n0 + 2, "R9", rd, 32'h99);
    chk(core_tx_ready === 1'b1, "R10", {31'b0, core_tx_ready}, 32'h1);
    pulse_done();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule